// File: doc/BRIEF.md
# Page-Mode Nonvolatile Memory Write Controller

This block is a synchronous model of the control logic of a byte-wide nonvolatile memory. It samples active-low chip-select, output-enable and write-strobe pins on each clock edge, along with an address bus and a data bus, and turns them into reads, single-byte writes and page writes. Written bytes collect in a page buffer. A page-load timer restarts with every accepted byte, and when it runs out without a new strobe, a long internal programming cycle (a cycle counter) copies the buffered bytes into the storage array.

While a page is loading or being programmed, a read does not return array data. It returns a status word: a polling bit that is the inverse of bit 7 of the last byte taken, a bit that toggles on every read, and a bit that shows whether the load window is still open. A separate pull-down output marks the programming cycle, so the host can use hardware or software handshaking. For a set number of cycles after reset, all writes are blocked.

Top module: `eep_page_ctrl`

## Requirements
- R1: When chip select is low, output enable is low, write strobe is high and the block is idle, `dqOe` is 8'hFF and `dqOut` holds the array byte at `addr`. Whenever chip select or output enable is high, `dqOe` is 0.
- R2: A write cycle is recognised only while chip select and write strobe are both low with output enable high. A strobe pulse made with output enable low loads nothing and starts no programming.
- R3: The address is taken in the cycle where the later of chip select and write strobe goes low. The data is taken in the cycle where the earlier of the two goes high.
- R4: A page holds PAGE_BYTES (32) bytes, selected by address bits [4:0]. The first byte fixes address bits [10:5] for the page. A later byte with different upper bits is dropped and does not reach the array.
- R5: Every accepted byte restarts a load window of LOAD_WINDOW cycles. The timer is frozen while an accepted strobe is low. Programming starts when the window runs out.
- R6: Programming lasts PROG_CYCLES cycles. At its end, every loaded byte is written to the array and the block returns to idle.
- R7: During a load or a programming cycle, read bit 7 is the inverse of bit 7 of the last accepted byte. Once the cycle has ended, reads return the true stored byte.
- R8: During a load or a programming cycle, read bit 6 inverts after each completed read. In idle it does not appear on the bus.
- R9: During a load or a programming cycle, a read drives only bits 7..5 (`dqOe` = 8'hE0). Bit 5 is 1 while the load window is open and 0 during programming.
- R10: `rbPullLow` is 1 exactly while programming runs and 0 otherwise.
- R11: For LOCKOUT_CYCLES cycles after reset, write strobes are ignored.
- R12: Write strobes that arrive during programming are ignored. They change neither the array nor the programming length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset (power-on) |
| ceN | input | 1 | Chip select, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write strobe, active low |
| addr | input | 11 | Byte address |
| dqIn | input | 8 | Data bus from host |
| dqOut | output | 8 | Data bus to host |
| dqOe | output | 8 | Per-bit drive enable of `dqOut` |
| rbPullLow | output | 1 | Open-drain ready/busy: 1 pulls the line low (busy) |

## Verification
The bench builds the block with LOAD_WINDOW = 20, PROG_CYCLES = 100 and LOCKOUT_CYCLES = 10, in place of the real-time defaults. This brings window expiry, retriggering with gaps just under the window, full programming cycles and the post-reset lockout within a few hundred cycles each. It can therefore run several complete page writes, and reads during both the load and programming phases, in one short run.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [1:0] {
    ST_READY = 2'd0,
    ST_LOAD  = 2'd1,
    ST_PROG  = 2'd2
  } eep_state_t;

  // Strobes from control to datapath, one cycle each.
  typedef struct packed {
    logic latchAddr;   // take address from the bus
    logic loadByte;    // put bus data into the page buffer
    logic newPage;     // first byte of a page: fix the page base
    logic commit;      // copy the page buffer into the array
    logic flipToggle;  // a status read has completed
  } eep_strobe_t;

endpackage

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int LOAD_WINDOW    = 15000,
  parameter int PROG_CYCLES    = 500000,
  parameter int LOCKOUT_CYCLES = 500000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ceN,
  input  logic        oeN,
  input  logic        weN,
  input  logic        sameUpper,
  output eep_strobe_t strobe,
  output logic        readEn,
  output logic        busy,
  output logic        loadOpen,
  output logic        progActive
);

  localparam int LOAD_W = $clog2(LOAD_WINDOW + 1);
  localparam int PROG_W = $clog2(PROG_CYCLES + 1);
  localparam int LOCK_W = $clog2(LOCKOUT_CYCLES + 1);

  eep_state_t  state;
  logic [LOAD_W-1:0] loadCnt;
  logic [PROG_W-1:0] progCnt;
  logic [LOCK_W-1:0] lockCnt;
  logic prevWrite, prevRead, armed;

  logic writeActive, writeStart, writeEnd, allowed, accept, readEnd;

  assign writeActive = !ceN && !weN && oeN;
  assign readEn      = !ceN && !oeN && weN;
  assign writeStart  = writeActive && !prevWrite;
  // first of chip select / write strobe rising; output enable low inhibits
  assign writeEnd    = prevWrite && oeN && (ceN || weN);
  assign allowed     = (lockCnt == '0) && (state != ST_PROG);
  assign accept      = writeEnd && armed &&
                       ((state == ST_READY) || ((state == ST_LOAD) && sameUpper));
  assign readEnd     = prevRead && !readEn;

  assign busy       = (state != ST_READY);
  assign loadOpen   = (state == ST_LOAD);
  assign progActive = (state == ST_PROG);

  always_comb begin
    strobe            = '0;
    strobe.latchAddr  = writeStart && allowed;
    strobe.loadByte   = accept;
    strobe.newPage    = accept && (state == ST_READY);
    strobe.commit     = (state == ST_PROG) && (progCnt <= PROG_W'(1));
    strobe.flipToggle = readEnd && busy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_READY;
      loadCnt   <= '0;
      progCnt   <= '0;
      lockCnt   <= LOCK_W'(LOCKOUT_CYCLES);
      prevWrite <= 1'b0;
      prevRead  <= 1'b0;
      armed     <= 1'b0;
    end else begin
      prevWrite <= writeActive;
      prevRead  <= readEn;
      if (lockCnt != '0) lockCnt <= lockCnt - LOCK_W'(1);

      if (writeStart)    armed <= allowed;
      else if (writeEnd) armed <= 1'b0;

      unique case (state)
        ST_READY: begin
          if (accept) begin
            state   <= ST_LOAD;
            loadCnt <= LOAD_W'(LOAD_WINDOW);
          end
        end
        ST_LOAD: begin
          if (accept) begin
            loadCnt <= LOAD_W'(LOAD_WINDOW);
          end else if (!armed) begin
            if (loadCnt <= LOAD_W'(1)) begin
              state   <= ST_PROG;
              progCnt <= PROG_W'(PROG_CYCLES);
            end else begin
              loadCnt <= loadCnt - LOAD_W'(1);
            end
          end
        end
        ST_PROG: begin
          if (progCnt <= PROG_W'(1)) state <= ST_READY;
          else progCnt <= progCnt - PROG_W'(1);
        end
        default: state <= ST_READY;
      endcase
    end
  end

endmodule

// File: rtl/eep_datapath.sv
module eep_datapath
  import eep_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dqIn,
  input  eep_strobe_t       strobe,
  input  logic              readEn,
  input  logic              busy,
  input  logic              loadOpen,
  output logic              sameUpper,
  output logic [DATA_W-1:0] dqOut,
  output logic [DATA_W-1:0] dqOe
);

  localparam int OFFS_W  = $clog2(PAGE_BYTES);
  localparam int UPPER_W = ADDR_W - OFFS_W;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam logic [DATA_W-1:0] STATUS_MASK = {3'b111, {(DATA_W-3){1'b0}}};

  logic [DATA_W-1:0]     mem [DEPTH];
  logic [DATA_W-1:0]     pageData [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pageValid;
  logic [UPPER_W-1:0]    pageBase;
  logic [ADDR_W-1:0]     latchedAddr;
  logic                  lastTop;
  logic                  toggleBit;

  logic [OFFS_W-1:0]  latchedOffs;
  logic [UPPER_W-1:0] latchedUpper;
  logic [DATA_W-1:0]  statusWord;

  assign latchedOffs  = latchedAddr[OFFS_W-1:0];
  assign latchedUpper = latchedAddr[ADDR_W-1:OFFS_W];
  assign sameUpper    = (latchedUpper == pageBase);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchedAddr <= '0;
      pageValid   <= '0;
      pageBase    <= '0;
      lastTop     <= 1'b0;
      toggleBit   <= 1'b0;
    end else begin
      if (strobe.latchAddr) latchedAddr <= addr;
      if (strobe.flipToggle) toggleBit <= ~toggleBit;
      if (strobe.commit) begin
        pageValid <= '0;
      end else if (strobe.loadByte) begin
        lastTop <= dqIn[DATA_W-1];
        if (strobe.newPage) begin
          pageBase  <= latchedUpper;
          pageValid <= PAGE_BYTES'(1) << latchedOffs;
        end else begin
          pageValid[latchedOffs] <= 1'b1;
        end
      end
    end
  end

  // page buffer data and the array carry no reset
  always_ff @(posedge clk) begin
    if (strobe.loadByte) pageData[latchedOffs] <= dqIn;
  end

  always_ff @(posedge clk) begin
    if (strobe.commit) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (pageValid[i]) mem[{pageBase, OFFS_W'(i)}] <= pageData[i];
      end
    end
  end

  always_comb begin
    statusWord           = '0;
    statusWord[DATA_W-1] = ~lastTop;
    statusWord[DATA_W-2] = toggleBit;
    statusWord[DATA_W-3] = loadOpen;
  end

  assign dqOut = busy ? statusWord : mem[addr];
  assign dqOe  = !readEn ? '0 : (busy ? STATUS_MASK : '1);

endmodule

// File: rtl/eep_page_ctrl.sv
module eep_page_ctrl
  import eep_pkg::*;
#(
  parameter int ADDR_W         = 11,
  parameter int DATA_W         = 8,
  parameter int PAGE_BYTES     = 32,
  parameter int LOAD_WINDOW    = 15000,
  parameter int PROG_CYCLES    = 500000,
  parameter int LOCKOUT_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] dqOut,
  output logic [DATA_W-1:0] dqOe,
  output logic              rbPullLow
);

  eep_strobe_t strobe;
  logic readEn, busy, loadOpen, progActive, sameUpper;

  eep_ctrl #(
    .LOAD_WINDOW   (LOAD_WINDOW),
    .PROG_CYCLES   (PROG_CYCLES),
    .LOCKOUT_CYCLES(LOCKOUT_CYCLES)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .ceN       (ceN),
    .oeN       (oeN),
    .weN       (weN),
    .sameUpper (sameUpper),
    .strobe    (strobe),
    .readEn    (readEn),
    .busy      (busy),
    .loadOpen  (loadOpen),
    .progActive(progActive)
  );

  eep_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PAGE_BYTES(PAGE_BYTES)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .addr     (addr),
    .dqIn     (dqIn),
    .strobe   (strobe),
    .readEn   (readEn),
    .busy     (busy),
    .loadOpen (loadOpen),
    .sameUpper(sameUpper),
    .dqOut    (dqOut),
    .dqOe     (dqOe)
  );

  assign rbPullLow = progActive;

endmodule

// File: rtl/eep_page_ctrl_chk.sv
module eep_page_ctrl_chk #(
  parameter int DATA_W         = 8,
  parameter int PROG_CYCLES    = 500000,
  parameter int LOCKOUT_CYCLES = 500000
) (
  input logic              clk,
  input logic              rstN,
  input logic              ceN,
  input logic              oeN,
  input logic              weN,
  input logic [DATA_W-1:0] dqOut,
  input logic [DATA_W-1:0] dqOe,
  input logic              rbPullLow
);

  localparam int PROG_W = $clog2(PROG_CYCLES + 2);
  localparam int LOCK_W = $clog2(LOCKOUT_CYCLES + 2);
  localparam logic [DATA_W-1:0] STATUS_MASK = {3'b111, {(DATA_W-3){1'b0}}};

  logic readNow;
  logic [PROG_W-1:0] busyLen;
  logic [LOCK_W-1:0] sinceReset;

  assign readNow = !ceN && !oeN && weN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyLen    <= '0;
      sinceReset <= '0;
    end else begin
      busyLen <= rbPullLow ? busyLen + PROG_W'(1) : '0;
      if (sinceReset != LOCK_W'(LOCKOUT_CYCLES)) sinceReset <= sinceReset + LOCK_W'(1);
    end
  end

  p_tristate_r1: assert property (@(posedge clk) disable iff (!rstN)
    (ceN || oeN) |-> (dqOe == '0));

  p_status_mask_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rbPullLow && readNow) |-> (dqOe == STATUS_MASK));

  p_plts_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rbPullLow && readNow) |-> !dqOut[DATA_W-3]);

  p_prog_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rbPullLow) |-> (busyLen == PROG_W'(PROG_CYCLES)));

  p_lockout_r11: assert property (@(posedge clk) disable iff (!rstN)
    (sinceReset < LOCK_W'(LOCKOUT_CYCLES)) |-> !rbPullLow);

  p_poll_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rbPullLow && $past(rbPullLow) && readNow && $past(readNow))
      |-> $stable(dqOut[DATA_W-1]));

endmodule

bind eep_page_ctrl eep_page_ctrl_chk #(
  .DATA_W        (DATA_W),
  .PROG_CYCLES   (PROG_CYCLES),
  .LOCKOUT_CYCLES(LOCKOUT_CYCLES)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .ceN      (ceN),
  .oeN      (oeN),
  .weN      (weN),
  .dqOut    (dqOut),
  .dqOe     (dqOe),
  .rbPullLow(rbPullLow)
);

// File: tb/eep_page_ctrl_test.sv
module eep_page_ctrl_test;

  localparam int W = 20;
  localparam int P = 100;
  localparam int L = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic [10:0] addr = '0;
  logic [7:0]  dqIn = '0;
  logic [7:0]  dqOut, dqOe;
  logic        rbPullLow;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  eep_page_ctrl #(
    .LOAD_WINDOW(W), .PROG_CYCLES(P), .LOCKOUT_CYCLES(L)
  ) uut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .addr(addr), .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe), .rbPullLow(rbPullLow)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeByte(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; dqIn = d; ceN = 1'b0; weN = 1'b0; oeN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    ceN = 1'b1; weN = 1'b1;
    @(negedge clk);
  endtask

  task automatic readByte(input logic [10:0] a, output logic [7:0] v, output logic [7:0] oe);
    @(negedge clk);
    addr = a; ceN = 1'b0; oeN = 1'b0; weN = 1'b1;
    #1;
    v = dqOut; oe = dqOe;
    @(negedge clk);
    ceN = 1'b1; oeN = 1'b1;
    @(negedge clk);
  endtask

  task automatic waitProgDone();
    bit seenBusy = 1'b0;
    for (int i = 0; i < W + P + 60; i++) begin
      @(negedge clk);
      if (rbPullLow) seenBusy = 1'b1;
      else if (seenBusy) break;
    end
    check(seenBusy && !rbPullLow, "R6 programming completes", rbPullLow, 0);
  endtask

  task automatic testReset();
    check(rbPullLow == 1'b0, "R10 idle after reset", rbPullLow, 0);
    check(dqOe == 8'h00, "R1 bus released after reset", dqOe, 0);
  endtask

  task automatic testLockout();
    logic [7:0] v, oe;
    writeByte(11'h040, 8'h77);
    idle(W + 10);
    check(rbPullLow == 1'b0, "R11 write in lockout starts nothing", rbPullLow, 0);
    readByte(11'h040, v, oe);
    check(oe == 8'hFF, "R11 not busy after lockout write", oe, 8'hFF);
  endtask

  task automatic testSingle();
    logic [7:0] v, oe;
    writeByte(11'h300, 8'h11);
    idle(2);
    readByte(11'h300, v, oe);
    check(oe == 8'hE0, "R9 status mask while loading", oe, 8'hE0);
    check(v[5] == 1'b1, "R9 window bit set while loading", v[5], 1);
    check(v[7] == 1'b1, "R7 poll bit inverted while loading", v[7], 1);
    idle(W + 2);
    check(rbPullLow == 1'b1, "R10 busy during programming", rbPullLow, 1);
    readByte(11'h300, v, oe);
    check(v[5] == 1'b0, "R9 window bit clear while programming", v[5], 0);
    waitProgDone();
    readByte(11'h300, v, oe);
    check(v == 8'h11 && oe == 8'hFF, "R1 R6 single byte stored", v, 8'h11);
  endtask

  task automatic testToggle();
    logic [7:0] r1, r2, r3, r4, oe;
    writeByte(11'h123, 8'hA5);
    idle(W + 3);
    readByte(11'h123, r1, oe);
    readByte(11'h123, r2, oe);
    check(r1[6] != r2[6], "R8 toggle bit flips between reads", r2[6], !r1[6]);
    check(r1[7] == 1'b0, "R7 poll bit inverse of 1", r1[7], 0);
    waitProgDone();
    readByte(11'h123, r3, oe);
    readByte(11'h123, r4, oe);
    check(r3 == 8'hA5 && r4 == 8'hA5, "R7 R8 true data after completion", r4, 8'hA5);
  endtask

  task automatic testPage();
    logic [7:0] v, oe;
    writeByte(11'h2E0, 8'h01);
    writeByte(11'h2E5, 8'h25);
    writeByte(11'h2FF, 8'h7F);
    writeByte(11'h2E1, 8'h3C);
    writeByte(11'h300, 8'hEE);   // other page: must be dropped
    idle(W + 3);
    readByte(11'h2E1, v, oe);
    check(v[7] == 1'b1, "R4 R7 foreign byte not taken as last", v[7], 1);
    writeByte(11'h2E0, 8'hFF);   // during programming: ignored
    waitProgDone();
    readByte(11'h2E0, v, oe);
    check(v == 8'h01, "R12 write during programming ignored", v, 8'h01);
    readByte(11'h2E5, v, oe);
    check(v == 8'h25, "R4 page byte 5", v, 8'h25);
    readByte(11'h2FF, v, oe);
    check(v == 8'h7F, "R4 page byte 31", v, 8'h7F);
    readByte(11'h2E1, v, oe);
    check(v == 8'h3C, "R4 page byte 1", v, 8'h3C);
    readByte(11'h300, v, oe);
    check(v == 8'h11, "R4 foreign page byte untouched", v, 8'h11);
    idle(W);
    check(rbPullLow == 1'b0, "R12 no second programming cycle", rbPullLow, 0);
  endtask

  task automatic testRetrigger();
    logic [7:0] v, oe;
    writeByte(11'h400, 8'h10);
    idle(W - 6);
    writeByte(11'h401, 8'h20);
    idle(W - 6);
    writeByte(11'h402, 8'h30);
    idle(W - 6);
    check(rbPullLow == 1'b0, "R5 window retriggered", rbPullLow, 0);
    readByte(11'h402, v, oe);
    check(v[5] == 1'b1, "R5 still loading", v[5], 1);
    waitProgDone();
    readByte(11'h400, v, oe);
    check(v == 8'h10, "R5 first byte stored", v, 8'h10);
    readByte(11'h402, v, oe);
    check(v == 8'h30, "R5 last byte stored", v, 8'h30);
  endtask

  task automatic testInhibit();
    logic [7:0] v, oe;
    @(negedge clk);
    addr = 11'h500; dqIn = 8'h55; ceN = 1'b0; weN = 1'b0; oeN = 1'b0;
    idle(2);
    ceN = 1'b1; weN = 1'b1; oeN = 1'b1;
    idle(W + 5);
    check(rbPullLow == 1'b0, "R2 output enable low inhibits write", rbPullLow, 0);
    readByte(11'h500, v, oe);
    check(oe == 8'hFF, "R2 nothing loaded", oe, 8'hFF);
  endtask

  task automatic testEdges();
    logic [7:0] v, oe;
    @(negedge clk);
    addr = 11'h610; weN = 1'b0;
    @(negedge clk);
    addr = 11'h620; ceN = 1'b0;          // later falling edge: address taken
    @(negedge clk);
    addr = 11'h630; dqIn = 8'h9A;
    @(negedge clk);
    ceN = 1'b1;                          // earlier rising edge: data taken
    @(negedge clk);
    dqIn = 8'h0F;
    @(negedge clk);
    weN = 1'b1;
    waitProgDone();
    readByte(11'h620, v, oe);
    check(v == 8'h9A, "R3 address and data edges", v, 8'h9A);
  endtask

  task automatic testTristate();
    @(negedge clk);
    addr = 11'h620; ceN = 1'b1; oeN = 1'b0; weN = 1'b1;
    #1;
    check(dqOe == 8'h00, "R1 chip select high floats bus", dqOe, 0);
    @(negedge clk);
    ceN = 1'b0; oeN = 1'b1;
    #1;
    check(dqOe == 8'h00, "R1 output enable high floats bus", dqOe, 0);
    @(negedge clk);
    ceN = 1'b1;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLockout();
    testSingle();
    testToggle();
    testPage();
    testRetrigger();
    testInhibit();
    testEdges();
    testTristate();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule